// File: doc/BRIEF.md
# Eight-Channel Byte-Copy DMA Engine

This block moves bytes between a wide main bus and a narrow peripheral register page. The main bus (A side) is addressed with 24 bits: an 8-bit bank and a 16-bit offset. The peripheral side (B side) is addressed with an 8-bit register offset. Software configures one or more of eight channels through a small register window. It then writes a bitmask to a launch register. The engine services the selected channels one at a time, lowest number first, and holds the processor through a stall output until every selected channel has drained.

Each byte takes two bus cycles: one read cycle on the source bus and one write cycle on the destination bus. Because the source may be an I/O port whose read has side effects, every byte produces exactly one read strobe. There is never a preliminary or repeated read. The main-bus offset can count up, count down or stay put, as selected per channel. The bank never changes during a transfer, and the peripheral offset is constant for the whole transfer.

Top module: `dma_engine`

## Requirements
- R1: After reset, cpuStall is low, no bus strobe is active, the launch register reads 0x00 and every channel register reads 0x00.
- R2: Channel c owns register addresses 0x10*c+k. Offset k=0 is control, 1 is the peripheral offset, 2/3/4 are the main-bus offset low, offset high and bank, and 5/6 are the byte count low and high. All of them read back what was written. The launch register sits at 0x80.
- R3: Each byte is one read-strobe cycle followed immediately by one write-strobe cycle. The write carries the byte captured in the read cycle, and at most one strobe is active per cycle. A source byte is never read twice.
- R4: Control bit 7 picks the direction: 0 reads the main bus (aRd) and writes the peripheral (bWr), 1 reads the peripheral (bRd) and writes the main bus (aWr). bAddr always equals the channel's peripheral offset.
- R5: With control bits 3 and 4 both 0, the main-bus offset rises by one after each byte, wraps from 0xFFFF to 0x0000, and the bank stays unchanged. After the transfer, the offset registers read the stepped value.
- R6: With control bit 3 set, the main-bus address is the same for every byte whatever bit 4 holds, and the offset registers keep their value.
- R7: With control bit 3 clear and bit 4 set, the main-bus offset falls by one after each byte and wraps from 0x0000 to 0xFFFF.
- R8: The low COUNT_W bits of the count give the number of bytes. The count is decremented per byte and reads 0 when the channel is done. A count of 0 moves 2^COUNT_W bytes.
- R9: Writing mask m to 0x80 launches each channel c with bit c of m set. Channels run in ascending order, and a channel's bit in the launch register clears when its last byte is written.
- R10: cpuStall is high from the cycle after a nonzero launch write until the last selected channel finishes. Register writes, including writes to the launch register, are ignored while cpuStall is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 8 | Register address (channel window or launch register) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr (combinational) |
| cpuStall | output | 1 | Holds the processor while channels are pending |
| aAddr | output | 24 | Main-bus address (bank, offset) |
| aRd | output | 1 | Main-bus read strobe |
| aWr | output | 1 | Main-bus write strobe |
| aRdData | input | 8 | Main-bus read data, captured at the end of an aRd cycle |
| aWrData | output | 8 | Main-bus write data |
| bAddr | output | 8 | Peripheral register offset |
| bRd | output | 1 | Peripheral read strobe |
| bWr | output | 1 | Peripheral write strobe |
| bRdData | input | 8 | Peripheral read data, captured at the end of a bRd cycle |
| bWrData | output | 8 | Peripheral write data |

## Verification
The bench builds the engine with all eight channels and with COUNT_W set to 8. With that width, a zero count means a 256-byte transfer, so the zero-count wrap takes about five hundred cycles instead of more than a hundred thousand. The channel count stays at eight, so the launch-register ordering and the per-channel clearing are exercised across the full mask. Both the main bus and the peripheral side offer a counting I/O port whose value advances on every read strobe. Any repeated or spurious source read therefore shifts all later data and shows up in the scoreboard.

// File: rtl/dma_pkg.sv
package dma_pkg;

  // Widest channel index the strobe bundle can carry (up to 8 channels).
  localparam int CH_IDX_W = 3;

  // Control-byte bit positions decoded by the datapath.
  localparam int CTRL_FIXED_BIT = 3;
  localparam int CTRL_DEC_BIT   = 4;
  localparam int CTRL_DIR_BIT   = 7;

  // Launch register address.
  localparam logic [7:0] LAUNCH_ADDR = 8'h80;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_READ,
    SEQ_WRITE
  } seq_state_t;

  // Control -> datapath strobes.
  typedef struct packed {
    logic                rdCycle;
    logic                wrCycle;
    logic                stepByte;
    logic                clearStart;
    logic [CH_IDX_W-1:0] chSel;
  } dma_strobe_t;

endpackage

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] startMask,
  input  logic              lastByte,
  output dma_strobe_t       strobe
);

  seq_state_t          state;
  logic [CH_IDX_W-1:0] curCh;
  logic [CH_IDX_W-1:0] lowestCh;

  // Lowest pending channel wins.
  always_comb begin
    lowestCh = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (startMask[i]) lowestCh = CH_IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      curCh <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (|startMask) begin
            curCh <= lowestCh;
            state <= SEQ_READ;
          end
        end
        SEQ_READ:  state <= SEQ_WRITE;
        SEQ_WRITE: state <= lastByte ? SEQ_IDLE : SEQ_READ;
        default:   state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.chSel      = curCh;
    strobe.rdCycle    = (state == SEQ_READ);
    strobe.wrCycle    = (state == SEQ_WRITE);
    strobe.stepByte   = (state == SEQ_WRITE);
    strobe.clearStart = (state == SEQ_WRITE) && lastByte;
  end

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int COUNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  dma_strobe_t       strobe,
  output logic [NUM_CH-1:0] startMask,
  output logic              lastByte,
  output logic [23:0]       aAddr,
  output logic              aRd,
  output logic              aWr,
  input  logic [7:0]        aRdData,
  output logic [7:0]        aWrData,
  output logic [7:0]        bAddr,
  output logic              bRd,
  output logic              bWr,
  input  logic [7:0]        bRdData,
  output logic [7:0]        bWrData
);

  localparam logic [15:0] LOW_MASK = 16'((32'd1 << COUNT_W) - 32'd1);

  logic [7:0]  ctrlQ  [NUM_CH];
  logic [7:0]  tgtQ   [NUM_CH];
  logic [15:0] srcLoQ [NUM_CH];
  logic [7:0]  bankQ  [NUM_CH];
  logic [15:0] cntQ   [NUM_CH];

  logic busy;
  logic wrOpen;
  logic [CH_IDX_W-1:0] winCh;
  logic [3:0] winOff;

  assign busy   = |startMask;
  assign wrOpen = regWrEn && !busy;
  assign winCh  = regAddr[6:4];
  assign winOff = regAddr[3:0];

  // Per-channel register block with its own stepping logic.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [7:0]  ctrlR;
    logic [7:0]  tgtR;
    logic [15:0] srcLoR;
    logic [7:0]  bankR;
    logic [15:0] cntR;
    logic        hit;
    logic        step;

    assign hit  = wrOpen && !regAddr[7] && (winCh == CH_IDX_W'(c));
    assign step = strobe.stepByte && (strobe.chSel == CH_IDX_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlR  <= '0;
        tgtR   <= '0;
        srcLoR <= '0;
        bankR  <= '0;
        cntR   <= '0;
      end else if (hit) begin
        unique case (winOff)
          4'd0:    ctrlR         <= regWrData;
          4'd1:    tgtR          <= regWrData;
          4'd2:    srcLoR[7:0]   <= regWrData;
          4'd3:    srcLoR[15:8]  <= regWrData;
          4'd4:    bankR         <= regWrData;
          4'd5:    cntR[7:0]     <= regWrData;
          4'd6:    cntR[15:8]    <= regWrData;
          default: ;
        endcase
      end else if (step) begin
        cntR <= (cntR & ~LOW_MASK) | ((cntR - 16'd1) & LOW_MASK);
        if (!ctrlR[CTRL_FIXED_BIT]) begin
          srcLoR <= ctrlR[CTRL_DEC_BIT] ? (srcLoR - 16'd1) : (srcLoR + 16'd1);
        end
      end
    end

    assign ctrlQ[c]  = ctrlR;
    assign tgtQ[c]   = tgtR;
    assign srcLoQ[c] = srcLoR;
    assign bankQ[c]  = bankR;
    assign cntQ[c]   = cntR;
  end

  // Launch register: loaded only while idle, bits drop as channels end.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startMask <= '0;
    end else if (wrOpen && (regAddr == LAUNCH_ADDR)) begin
      startMask <= regWrData[NUM_CH-1:0];
    end else if (strobe.clearStart) begin
      startMask[strobe.chSel] <= 1'b0;
    end
  end

  // Register read mux.
  always_comb begin
    regRdData = '0;
    if (regAddr == LAUNCH_ADDR) begin
      regRdData = 8'(startMask);
    end else if (!regAddr[7] && (int'(winCh) < NUM_CH)) begin
      unique case (winOff)
        4'd0:    regRdData = ctrlQ[winCh];
        4'd1:    regRdData = tgtQ[winCh];
        4'd2:    regRdData = srcLoQ[winCh][7:0];
        4'd3:    regRdData = srcLoQ[winCh][15:8];
        4'd4:    regRdData = bankQ[winCh];
        4'd5:    regRdData = cntQ[winCh][7:0];
        4'd6:    regRdData = cntQ[winCh][15:8];
        default: regRdData = '0;
      endcase
    end
  end

  // Byte sequencing on the active channel.
  logic       dirToA;
  logic [7:0] dataLatch;

  assign dirToA   = ctrlQ[strobe.chSel][CTRL_DIR_BIT];
  assign lastByte = (cntQ[strobe.chSel] & LOW_MASK) == 16'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataLatch <= '0;
    end else if (strobe.rdCycle) begin
      dataLatch <= dirToA ? bRdData : aRdData;
    end
  end

  assign aAddr   = {bankQ[strobe.chSel], srcLoQ[strobe.chSel]};
  assign bAddr   = tgtQ[strobe.chSel];
  assign aRd     = strobe.rdCycle && !dirToA;
  assign bRd     = strobe.rdCycle && dirToA;
  assign bWr     = strobe.wrCycle && !dirToA;
  assign aWr     = strobe.wrCycle && dirToA;
  assign aWrData = dataLatch;
  assign bWrData = dataLatch;

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int COUNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  output logic        cpuStall,
  output logic [23:0] aAddr,
  output logic        aRd,
  output logic        aWr,
  input  logic [7:0]  aRdData,
  output logic [7:0]  aWrData,
  output logic [7:0]  bAddr,
  output logic        bRd,
  output logic        bWr,
  input  logic [7:0]  bRdData,
  output logic [7:0]  bWrData
);

  dma_strobe_t       strobe;
  logic [NUM_CH-1:0] startMask;
  logic              lastByte;

  dma_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startMask (startMask),
    .lastByte  (lastByte),
    .strobe    (strobe)
  );

  dma_datapath #(.NUM_CH(NUM_CH), .COUNT_W(COUNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobe    (strobe),
    .startMask (startMask),
    .lastByte  (lastByte),
    .aAddr     (aAddr),
    .aRd       (aRd),
    .aWr       (aWr),
    .aRdData   (aRdData),
    .aWrData   (aWrData),
    .bAddr     (bAddr),
    .bRd       (bRd),
    .bWr       (bWr),
    .bRdData   (bRdData),
    .bWrData   (bWrData)
  );

  assign cpuStall = |startMask;

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cpuStall,
  input logic       aRd,
  input logic       aWr,
  input logic [7:0] aRdData,
  input logic [7:0] aWrData,
  input logic       bRd,
  input logic       bWr,
  input logic [7:0] bRdData,
  input logic [7:0] bWrData
);

  // R3: never more than one bus strobe in a cycle
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({aRd, aWr, bRd, bWr}));

  // R3: a read cycle is never directly followed by another read
  p_no_double_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (aRd || bRd) |=> !(aRd || bRd));

  // R3/R4: main-bus read is followed by a peripheral write of that byte
  p_a_to_b_r4: assert property (@(posedge clk) disable iff (!rstN)
    aRd |=> (bWr && (bWrData == $past(aRdData))));

  // R3/R4: peripheral read is followed by a main-bus write of that byte
  p_b_to_a_r4: assert property (@(posedge clk) disable iff (!rstN)
    bRd |=> (aWr && (aWrData == $past(bRdData))));

  // R10: bus activity only while the processor is held
  p_stall_covers_r10: assert property (@(posedge clk) disable iff (!rstN)
    (aRd || aWr || bRd || bWr) |-> cpuStall);

endmodule

bind dma_engine dma_engine_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuStall (cpuStall),
  .aRd      (aRd),
  .aWr      (aWr),
  .aRdData  (aRdData),
  .aWrData  (aWrData),
  .bRd      (bRd),
  .bWr      (bWr),
  .bRdData  (bRdData),
  .bWrData  (bWrData)
);

// File: tb/dma_engine_test.sv
module dma_engine_test;

  localparam int CNT_W = 8;
  localparam logic [23:0] IO_ADDR = 24'h00_4218;
  localparam int K_ARD = 0, K_BRD = 1, K_AWR = 2, K_BWR = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic cpuStall;
  logic [23:0] aAddr;
  logic aRd, aWr, bRd, bWr;
  logic [7:0] aRdData, aWrData, bAddr, bRdData, bWrData;

  logic [7:0] aPortCnt = '0;
  logic [7:0] bPortCnt = '0;
  logic [7:0] aPortModel = '0;
  logic [7:0] bPortModel = '0;

  int total = 0;
  int bad = 0;
  int popCnt = 0;

  typedef struct {
    int          kind;
    logic [23:0] addr;
    logic [7:0]  data;
    string       req;
  } item_t;
  item_t expQ[$];

  always #10 clk = ~clk;

  function automatic logic [7:0] memVal(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // Memory plus a side-effecting port on each bus.
  assign aRdData = (aAddr == IO_ADDR) ? aPortCnt : memVal(aAddr);
  assign bRdData = bPortCnt;
  always @(posedge clk) begin
    if (aRd && aAddr == IO_ADDR) aPortCnt <= aPortCnt + 8'd1;
    if (bRd) bPortCnt <= bPortCnt + 8'd1;
  end

  dma_engine #(.NUM_CH(8), .COUNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cpuStall(cpuStall),
    .aAddr(aAddr), .aRd(aRd), .aWr(aWr), .aRdData(aRdData), .aWrData(aWrData),
    .bAddr(bAddr), .bRd(bRd), .bWr(bWr), .bRdData(bRdData), .bWrData(bWrData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per observed strobe.
  always @(negedge clk) begin
    if (rstN && (aRd || bRd || aWr || bWr)) begin
      int k;
      logic [23:0] addr;
      logic [7:0] data;
      k = aRd ? K_ARD : bRd ? K_BRD : aWr ? K_AWR : K_BWR;
      addr = (k == K_ARD || k == K_AWR) ? aAddr : {16'h0, bAddr};
      data = (k == K_AWR) ? aWrData : bWrData;
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "unexpected strobe kind", 32'(k), 32'hFF);
      end else begin
        item_t e;
        e = expQ.pop_front();
        popCnt++;
        check(k == e.kind, e.req, "strobe kind", 32'(k), 32'(e.kind));
        check(addr == e.addr, e.req, "address", 32'(addr), 32'(e.addr));
        if (k == K_AWR || k == K_BWR)
          check(data == e.data, e.req, "write data", 32'(data), 32'(e.data));
      end
    end
  end

  task automatic regWr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic expectReg(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    regRd(a, v);
    check(v == exp, req, $sformatf("reg %0h", a), 32'(v), 32'(exp));
  endtask

  // Driver: program a channel and queue the bus items it must produce.
  task automatic setupCh(input int ch, input logic [7:0] ctl, input logic [7:0] tgt,
                         input logic [23:0] src, input logic [15:0] cnt, input string req);
    logic [7:0] base;
    logic [15:0] lo;
    int n;
    base = 8'(ch * 16);
    regWr(base + 8'd0, ctl);
    regWr(base + 8'd1, tgt);
    regWr(base + 8'd2, src[7:0]);
    regWr(base + 8'd3, src[15:8]);
    regWr(base + 8'd4, src[23:16]);
    regWr(base + 8'd5, cnt[7:0]);
    regWr(base + 8'd6, cnt[15:8]);
    n = (int'(cnt[CNT_W-1:0]) == 0) ? (1 << CNT_W) : int'(cnt[CNT_W-1:0]);
    lo = src[15:0];
    for (int i = 0; i < n; i++) begin
      logic [23:0] a;
      logic [7:0] d;
      a = {src[23:16], lo};
      if (!ctl[7]) begin
        if (a == IO_ADDR) begin d = aPortModel; aPortModel = aPortModel + 8'd1; end
        else d = memVal(a);
        expQ.push_back('{K_ARD, a, 8'h00, req});
        expQ.push_back('{K_BWR, {16'h0, tgt}, d, req});
      end else begin
        d = bPortModel; bPortModel = bPortModel + 8'd1;
        expQ.push_back('{K_BRD, {16'h0, tgt}, 8'h00, req});
        expQ.push_back('{K_AWR, a, d, req});
      end
      if (!ctl[3]) lo = ctl[4] ? lo - 16'd1 : lo + 16'd1;
    end
  endtask

  task automatic waitDone(input string req);
    while (cpuStall) @(negedge clk);
    check(expQ.size() == 0, req, "items left after stall dropped", 32'(expQ.size()), 0);
    expectReg(8'h80, 8'h00, "R9");
  endtask

  task automatic launch(input logic [7:0] m);
    regWr(8'h80, m);
    check(cpuStall == 1'b1, "R10", "stall after launch", 32'(cpuStall), 1);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cpuStall == 1'b0, "R1", "stall in reset", 32'(cpuStall), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!(aRd || aWr || bRd || bWr), "R1", "strobes after reset",
          32'({aRd, aWr, bRd, bWr}), 0);
    expectReg(8'h80, 8'h00, "R1");
    expectReg(8'h30, 8'h00, "R1");
    expectReg(8'h75, 8'h00, "R1");

    // R2: register window readback for channel 5
    for (int k = 0; k < 7; k++) regWr(8'(8'h50 + k), 8'(8'hA1 + 8'(k * 17)));
    for (int k = 0; k < 7; k++) expectReg(8'(8'h50 + k), 8'(8'hA1 + 8'(k * 17)), "R2");

    // R3 R4 R5: main bus to peripheral, incrementing source
    setupCh(0, 8'h00, 8'h80, 24'h12_3400, 16'd5, "R5");
    launch(8'h01);
    waitDone("R3");
    expectReg(8'h02, 8'h05, "R5");
    expectReg(8'h03, 8'h34, "R5");
    expectReg(8'h04, 8'h12, "R5");
    expectReg(8'h05, 8'h00, "R8");

    // R4: peripheral I/O port to main bus, each port value read once
    setupCh(1, 8'h80, 8'h3C, 24'h7E_1000, 16'd4, "R4");
    launch(8'h02);
    waitDone("R4");

    // R6: fixed source on a main-bus I/O port, bit 4 clear then set
    setupCh(2, 8'h08, 8'h18, IO_ADDR, 16'd6, "R6");
    launch(8'h04);
    waitDone("R6");
    expectReg(8'h22, 8'h18, "R6");
    expectReg(8'h23, 8'h42, "R6");
    setupCh(2, 8'h18, 8'h19, IO_ADDR, 16'd3, "R6");
    launch(8'h04);
    waitDone("R6");

    // R7: decrementing with wrap below zero, bank held
    setupCh(3, 8'h10, 8'h04, 24'h05_0001, 16'd3, "R7");
    launch(8'h08);
    waitDone("R7");
    expectReg(8'h32, 8'hFE, "R7");
    expectReg(8'h33, 8'hFF, "R7");
    expectReg(8'h34, 8'h05, "R7");

    // R5: incrementing with wrap above 0xFFFF, bank held
    setupCh(4, 8'h00, 8'h22, 24'h09_FFFE, 16'd3, "R5");
    launch(8'h10);
    waitDone("R5");
    expectReg(8'h42, 8'h01, "R5");
    expectReg(8'h43, 8'h00, "R5");
    expectReg(8'h44, 8'h09, "R5");

    // R9 R10: two channels in ascending order, writes while stalled ignored
    setupCh(2, 8'h00, 8'h11, 24'h20_0100, 16'd10, "R9");
    setupCh(6, 8'h80, 8'h12, 24'h21_0200, 16'd4, "R9");
    base = popCnt;
    launch(8'h44);
    regWr(8'h70, 8'hFF);
    regWr(8'h80, 8'h01);
    while (popCnt < base + 20) @(posedge clk);
    expectReg(8'h80, 8'h40, "R9");
    waitDone("R9");
    expectReg(8'h70, 8'h00, "R10");
    check(cpuStall == 1'b0, "R10", "stall after finish", 32'(cpuStall), 0);

    // R8: zero count moves 2^COUNT_W bytes
    setupCh(7, 8'h00, 8'h80, 24'h01_0000, 16'd0, "R8");
    launch(8'h80);
    waitDone("R8");
    expectReg(8'h75, 8'h00, "R8");
    expectReg(8'h72, 8'h00, "R8");
    expectReg(8'h73, 8'h01, "R8");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule